// File: doc/BRIEF.md
# Service Gate Capture Sequencer

This block sits on the device side of a polled channel interface. It turns a poll that the device has already claimed into a service selection. Once selected, it sends the delayed return tags back to the channel. A claimed poll is held in a poll latch. The capture trigger sets only when that latch and the service gate line are both active. The data strobe line plays no part in setting the trigger. As a result, strobes meant for storage can never produce a return tag from a device that the channel did not select.

The trigger clears the poll latch one cycle after the trigger itself has settled. This ordering removes the race between testing the latch and setting the trigger. The trigger drops only after both service gate and data strobe have gone inactive, whichever falls last. The service gate and data strobe lines arrive asynchronously, so each passes through a two-flop synchronizer first.

Two envelopes are offered to the device's data path. One is selection combined with gate, the other is selection combined with strobe. Each return tag is its envelope delayed by a parameterised number of cycles. Any of the synchronous channel resets deselects the device and removes both tags at once.

Top module: `svc_gate_seq`

## Requirements
- R1: After rst_n is released, state reads 0 (idle), and poll_latched, capture_trig, gate_ret and strobe_ret are all 0.
- R2: A one-cycle pulse on poll_claim sets poll_latched at the next clock edge. The latch then holds until the capture trigger is set or a channel reset arrives.
- R3: The state encoding is idle=0, captured=1, selected=2, release=3. The state moves from idle to captured only while poll_latched is 1 and the synchronized service gate is 1. An active data strobe without service gate never causes a capture.
- R4: The state spends exactly one cycle in captured and then moves to selected. poll_latched reads 0 from the first cycle after the capture trigger is set.
- R5: While selected, the trigger returns to idle only when the synchronized gate and strobe are both 0. If the gate falls while the strobe is still 1, the state enters release and stays there until the strobe also falls.
- R6: A data strobe arriving while capture_trig is 0 never asserts strobe_ret or gate_ret.
- R7: Each return tag rises RET_DELAY cycles (default 2) after its envelope rises. It drops in the same cycle that its envelope falls.
- R8: Any bit of chan_rst removes both return tags in the same cycle. At the next edge it forces the state to idle and clears poll_latched.
- R9: service_gate_a and dstrobe_a take effect on the envelopes two clock edges after they change. They take effect on the state three edges after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| poll_claim | input | 1 | Pulse from the poll logic: this device has won the poll |
| svc_gate_a | input | 1 | Service gate line from the channel, asynchronous |
| dstrobe_a | input | 1 | Data strobe line from the channel, asynchronous |
| chan_rst | input | NUM_RST | Synchronous channel-directed resets, one bit each |
| state | output | 2 | Sequencer state: 0 idle, 1 captured, 2 selected, 3 release |
| capture_trig | output | 1 | Service gate capture trigger (device selected) |
| poll_latched | output | 1 | Poll capture latch |
| gate_env | output | 1 | Selection combined with synchronized service gate |
| strobe_env | output | 1 | Selection combined with synchronized data strobe |
| gate_ret | output | 1 | Delayed service gate return tag |
| strobe_ret | output | 1 | Delayed data strobe return tag |

## Verification
The hardest case to reach is the release state. Getting there needs service gate to drop while the strobe is still high, after a full capture has already happened. Because of the synchronizers, both async lines must be timed against the state register with an offset of several edges. The stimulus table drives gate and strobe with overlapping windows, then removes the gate two vectors before the strobe. A directed case then fires a channel reset while the state sits in release with the strobe tag high. This shows that the tag is removed in that same cycle.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [1:0] {
    SG_IDLE     = 2'd0,
    SG_CAPTURED = 2'd1,
    SG_SELECTED = 2'd2,
    SG_RELEASE  = 2'd3
  } sg_state_e;

  // Trigger may drop only once both interface lines are inactive.
  function automatic logic trig_may_drop(input logic gate, input logic strobe);
    return !gate && !strobe;
  endfunction

  // A return tag is due once the envelope age reaches the delay.
  function automatic logic tag_due(input int unsigned age, input int unsigned dly);
    return age == dly;
  endfunction
endpackage

// File: rtl/sgs_sync2.sv
module sgs_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= 1'b0;
        stage2[b] <= 1'b0;
      end else begin
        stage1[b] <= d_async[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/sgs_ret_delay.sv
module sgs_ret_delay #(
  parameter int RET_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic env,
  output logic tag
);
  localparam int CW = $clog2(RET_DELAY + 2);
  localparam logic [CW-1:0] DLY = CW'(RET_DELAY);

  logic [CW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (clr || !env)    age <= '0;
    else if (age != DLY)     age <= age + 1'b1;
  end

  assign tag = env && sgs_pkg::tag_due(32'(age), 32'(RET_DELAY));

  if (RET_DELAY > 0) begin : g_chk
    // R7
    tag_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(env) |-> !tag);
  end
endmodule

// File: rtl/sgs_fsm.sv
module sgs_fsm
  import sgs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_any,
  input  logic      poll_claim,
  input  logic      gate_s,
  input  logic      strobe_s,
  output sg_state_e st,
  output logic      trig,
  output logic      poll_q
);
  sg_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      SG_IDLE:     if (poll_q && gate_s) nxt = SG_CAPTURED;
      SG_CAPTURED: nxt = SG_SELECTED;
      SG_SELECTED,
      SG_RELEASE: begin
        if (trig_may_drop(gate_s, strobe_s)) nxt = SG_IDLE;
        else if (!gate_s)                    nxt = SG_RELEASE;
      end
      default:     nxt = SG_IDLE;
    endcase
    if (rst_any) nxt = SG_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SG_IDLE;
    else        st <= nxt;
  end

  assign trig = (st != SG_IDLE);

  // Poll latch is cleared by the settled trigger, never by its set condition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                poll_q <= 1'b0;
    else if (rst_any || trig)  poll_q <= 1'b0;
    else if (poll_claim)       poll_q <= 1'b1;
  end

  // R4
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !poll_q);
  // R4
  captured_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SG_CAPTURED && !rst_any) |=> st == SG_SELECTED);
  // R5
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SG_RELEASE && strobe_s && !rst_any) |=> st == SG_RELEASE);
endmodule

// File: rtl/svc_gate_seq.sv
module svc_gate_seq
  import sgs_pkg::*;
#(
  parameter int NUM_RST   = 3,
  parameter int RET_DELAY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll_claim,
  input  logic               svc_gate_a,
  input  logic               dstrobe_a,
  input  logic [NUM_RST-1:0] chan_rst,
  output logic [1:0]         state,
  output logic               capture_trig,
  output logic               poll_latched,
  output logic               gate_env,
  output logic               strobe_env,
  output logic               gate_ret,
  output logic               strobe_ret
);
  localparam int NUM_TAGS = 2;

  logic [1:0]          line_s;
  logic                gate_s;
  logic                strobe_s;
  logic                rst_any;
  sg_state_e           st;
  logic [NUM_TAGS-1:0] env_raw;
  logic [NUM_TAGS-1:0] env_vec;
  logic [NUM_TAGS-1:0] tag_vec;

  sgs_sync2 #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({dstrobe_a, svc_gate_a}),
    .q_sync  (line_s)
  );

  assign gate_s   = line_s[0];
  assign strobe_s = line_s[1];
  assign rst_any  = |chan_rst;

  sgs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_any    (rst_any),
    .poll_claim (poll_claim),
    .gate_s     (gate_s),
    .strobe_s   (strobe_s),
    .st         (st),
    .trig       (capture_trig),
    .poll_q     (poll_latched)
  );

  assign env_raw = {capture_trig && strobe_s, capture_trig && gate_s};
  assign env_vec = rst_any ? '0 : env_raw;

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    sgs_ret_delay #(.RET_DELAY(RET_DELAY)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rst_any),
      .env   (env_vec[t]),
      .tag   (tag_vec[t])
    );
  end

  assign state      = st;
  assign gate_env   = env_vec[0];
  assign strobe_env = env_vec[1];
  assign gate_ret   = tag_vec[0];
  assign strobe_ret = tag_vec[1];

  // R3
  capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_trig) |-> $past(gate_s && poll_latched));
  // R6
  no_stray_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ret || gate_ret) |-> capture_trig);
  // R8
  chan_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> (st == SG_IDLE && !poll_latched));
  // R8
  chan_rst_degate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |-> !(gate_ret || strobe_ret));
endmodule

// File: tb/svc_gate_seq_tb.sv
`timescale 1ns/1ps
module svc_gate_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_claim = 1'b0;
  logic       svc_gate_a = 1'b0;
  logic       dstrobe_a = 1'b0;
  logic [2:0] chan_rst = 3'b000;
  logic [1:0] state;
  logic       capture_trig, poll_latched, gate_env, strobe_env, gate_ret, strobe_ret;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  svc_gate_seq #(.NUM_RST(3), .RET_DELAY(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_claim(poll_claim),
    .svc_gate_a(svc_gate_a), .dstrobe_a(dstrobe_a), .chan_rst(chan_rst),
    .state(state), .capture_trig(capture_trig), .poll_latched(poll_latched),
    .gate_env(gate_env), .strobe_env(strobe_env),
    .gate_ret(gate_ret), .strobe_ret(strobe_ret)
  );

  // Row: {claim, gate, strobe, chan_rst[0], exp state[1:0], exp latch, exp gate_ret, exp strobe_ret}
  localparam int NV = 26;
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b0_0_0_0_00_0_0_0, 9'b1_0_0_0_00_1_0_0, 9'b0_1_0_0_00_1_0_0,
    9'b0_1_0_0_00_1_0_0, 9'b0_1_0_0_01_1_0_0, 9'b0_1_0_0_10_0_0_0,
    9'b0_1_1_0_10_0_1_0, 9'b0_1_1_0_10_0_1_0, 9'b0_0_1_0_10_0_1_0,
    9'b0_0_1_0_10_0_0_1, 9'b0_0_0_0_11_0_0_1, 9'b0_0_0_0_11_0_0_0,
    9'b0_0_0_0_00_0_0_0, 9'b0_0_1_0_00_0_0_0, 9'b0_0_1_0_00_0_0_0,
    9'b1_0_1_0_00_1_0_0, 9'b0_0_1_0_00_1_0_0, 9'b0_0_0_0_00_1_0_0,
    9'b0_1_0_0_00_1_0_0, 9'b0_1_0_0_00_1_0_0, 9'b0_1_0_0_01_1_0_0,
    9'b0_1_0_0_10_0_0_0, 9'b0_1_0_0_10_0_1_0, 9'b0_1_0_1_00_0_0_0,
    9'b0_1_0_0_00_0_0_0, 9'b0_0_0_0_00_0_0_0
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge; outputs are then sampled at the following falling edge.
  task automatic step(input logic c, input logic g, input logic s, input logic [2:0] r);
    poll_claim = c; svc_gate_a = g; dstrobe_a = s; chan_rst = r;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 latch", poll_latched, 0);
    check("R1 trigger", capture_trig, 0);
    check("R1 tags", {gate_ret, strobe_ret}, 0);

    // Table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], {2'b00, VEC[i][5]});
      check($sformatf("R3 R5 R9 state row %0d", i), state, VEC[i][4:3]);
      check($sformatf("R2 R4 latch row %0d", i), poll_latched, VEC[i][2]);
      check($sformatf("R7 R8 gate_ret row %0d", i), gate_ret, VEC[i][1]);
      check($sformatf("R6 R7 strobe_ret row %0d", i), strobe_ret, VEC[i][0]);
    end

    // Directed: reach release, then a channel reset on its top bit (R8).
    step(1'b1, 1'b1, 1'b0, 3'b000);
    repeat (5) step(1'b0, 1'b1, 1'b1, 3'b000);
    check("R4 selected before release", state, 2);
    repeat (3) step(1'b0, 1'b0, 1'b1, 3'b000);
    check("R5 release entered", state, 3);
    check("R7 strobe tag in release", strobe_ret, 1);
    check("R5 envelope still up", strobe_env, 1);
    chan_rst = 3'b100;
    #1;
    check("R8 tag removed same cycle", strobe_ret, 0);
    @(negedge clk);
    check("R8 state idle", state, 0);
    check("R8 latch clear", poll_latched, 0);
    step(1'b0, 1'b0, 1'b1, 3'b000);
    check("R8 stays deselected", capture_trig, 0);
    step(1'b0, 1'b0, 1'b0, 3'b000);
    check("R6 no tag after deselect", strobe_ret, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule